// File: doc/BRIEF.md
# Single-Wire Bit-Symbol Response Receiver

This block listens to a shared single-wire line on which every data bit travels as one whole asynchronous character. After the host has issued a transmit-request flag, the line carries first the echo of that flag and then the responder's answer. The receiver drops the echo and turns each answer character into one bit with a tolerant match. It packs the bits into bytes, least-significant bit first, and ends the response when the line has been quiet for a set number of bit periods.

Each character is framed as one low start bit, eight data bits (first bit on the wire is bit 0) and one high stop bit. Each bit lasts `CLKS_PER_BIT` clock cycles. A falling edge opens a character, and every bit is sampled at its middle. The received bytes leave the block as a stream with a valid strobe. Each byte is held back by one position, so the final byte can carry a last marker. A done pulse closes every response, and the count of stored bytes is valid when it fires.

The controller has five states. `ST_IDLE` waits for the start strobe. `ST_ECHO` swallows the echo characters. `ST_WAIT` waits for the first answer character under a long failsafe limit. `ST_COLLECT` gathers the answer under the short gap limit. `ST_DONE` lasts one cycle and flushes the held byte. The transitions are:
- idle→echo on `start_i`;
- echo→wait when the last echo character arrives;
- echo→done and wait→done when the failsafe limit expires;
- wait→collect on the first answer character;
- collect→done when the gap limit expires;
- done→idle unconditionally.

Top module: `swr_bitsym_rx`

## Requirements
- R1: Only the low seven bits of a character are used. A character whose low seven bits are 7'h7E or 7'h7F decodes as bit 1, and every other value (7'h7D, 7'h7C, 7'h00 and so on) decodes as bit 0.
- R2: Eight decoded bits form one byte. The first bit received lands in bit 0 and the eighth in bit 7, and bytes appear on `rsp_data_o` in arrival order.
- R3: The first `ECHO_CHARS` characters after `start_i` are discarded and never reach the byte stream.
- R4: A response ends once the line has been idle for `GAP_BITS` bit periods, measured from the stop-bit sample of the last character to the next falling edge. A shorter idle gap does not end the response.
- R5: When the response ends, answer characters that do not fill a whole group of eight are dropped and produce no byte.
- R6: At most `MAX_BYTES` bytes are delivered and counted. Further bytes are received and discarded, and `rsp_count_o` reports the number of bytes delivered.
- R7: `rsp_last_o` is raised only on the final delivered byte, in the same cycle as `rsp_valid_o` and the `done_o` pulse.
- R8: If no answer character arrives within `FAILSAFE_CYCLES` cycles of the start strobe or of the last echo activity, the response ends with zero bytes.
- R9: A character whose stop bit samples low sets the sticky `frame_err_o`. Its data bit is still decoded and counted. The next `start_i` clears the flag.
- R10: Characters that arrive after the done pulse and before the next start strobe are ignored.
- R11: After reset, `rsp_valid_o`, `rsp_last_o`, `done_o`, `rsp_count_o` and `frame_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Shared serial line, idle high |
| start_i | input | 1 | One-cycle strobe that opens a response capture |
| rsp_data_o | output | 8 | Received byte |
| rsp_valid_o | output | 1 | `rsp_data_o` holds a byte this cycle |
| rsp_last_o | output | 1 | Marks the final byte of the response |
| done_o | output | 1 | One-cycle pulse at the end of every response |
| rsp_count_o | output | $clog2(MAX_BYTES+1) | Bytes delivered; valid when `done_o` pulses |
| frame_err_o | output | 1 | Sticky stop-bit error for the current response |

## Verification
Two events can fall in the same cycle: the end of the response and the delivery of the final byte. The byte is held back until the gap timer expires, so its valid strobe, the last marker and the done pulse must coincide. The bench provokes this with responses of one to four bytes, with trailing partial groups, and with a count that hits the byte cap. It then judges that the last marker appears only on the final captured byte and never without done. Idle gaps just under and well over the limit show the same end condition from the other side: an early gap must not split a byte, and a late one must freeze the count while the rest of the characters go unused.

// File: rtl/swr_pkg.sv
package swr_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } chr_state_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ECHO,
        ST_WAIT,
        ST_COLLECT,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/swr_char_rx.sv
module swr_char_rx
    import swr_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic       busy_o,
    output logic       chr_valid_o,
    output logic [6:0] chr_data_o,
    output logic       chr_ferr_o
);
    localparam int CW   = $clog2(CLKS_PER_BIT) + 1;
    localparam int HALF = CLKS_PER_BIT / 2;

    logic [2:0]   sync_q;
    logic         rx_now, rx_prev;
    chr_state_t   state_q, state_d;
    logic [CW-1:0] tick_q;
    logic [2:0]   bit_q;
    logic [7:0]   shift_q;
    logic         period_end;

    assign rx_now  = sync_q[1];
    assign rx_prev = sync_q[2];
    assign busy_o  = (state_q != RX_IDLE);

    always_comb begin
        if (state_q == RX_START) period_end = (tick_q == CW'(HALF - 1));
        else                     period_end = (tick_q == CW'(CLKS_PER_BIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!rx_now && rx_prev) state_d = RX_START;
            RX_START: if (period_end) state_d = rx_now ? RX_IDLE : RX_DATA;
            RX_DATA:  if (period_end && bit_q == 3'd7) state_d = RX_STOP;
            RX_STOP:  if (period_end) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q      <= '0;
            bit_q       <= '0;
            shift_q     <= '0;
            chr_valid_o <= 1'b0;
            chr_data_o  <= '0;
            chr_ferr_o  <= 1'b0;
        end else begin
            chr_valid_o <= 1'b0;
            if (state_q == RX_IDLE || period_end) tick_q <= '0;
            else                                  tick_q <= tick_q + 1'b1;
            unique case (state_q)
                RX_IDLE:  bit_q <= '0;
                RX_START: bit_q <= '0;
                RX_DATA: begin
                    if (period_end) begin
                        shift_q <= {rx_now, shift_q[7:1]};
                        bit_q   <= bit_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (period_end) begin
                        chr_valid_o <= 1'b1;
                        chr_data_o  <= shift_q[6:0];
                        chr_ferr_o  <= !rx_now;
                    end
                end
                default: bit_q <= '0;
            endcase
        end
    end

    AST_CHR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid_o |=> !chr_valid_o); // R9

    AST_CHR_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid_o |-> $past(state_q == RX_STOP)); // R9

endmodule

// File: rtl/swr_packer.sv
module swr_packer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       sym_valid_i,
    input  logic       sym_bit_i,
    output logic       byte_valid_o,
    output logic [7:0] byte_o
);
    logic [2:0] idx_q;
    logic [7:0] sh_q;
    logic [7:0] sh_next;

    assign sh_next = {sym_bit_i, sh_q[7:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q        <= '0;
            sh_q         <= '0;
            byte_valid_o <= 1'b0;
            byte_o       <= '0;
        end else begin
            byte_valid_o <= 1'b0;
            if (clr_i) begin
                idx_q <= '0;
            end else if (sym_valid_i) begin
                sh_q  <= sh_next;
                idx_q <= idx_q + 1'b1;
                if (idx_q == 3'd7) begin
                    byte_valid_o <= 1'b1;
                    byte_o       <= sh_next;
                end
            end
        end
    end

    AST_BYTE_AFTER_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |-> $past(sym_valid_i)); // R2

endmodule

// File: rtl/swr_gap_timer.sv
module swr_gap_timer #(
    parameter int GAP_CYCLES      = 192,
    parameter int FAILSAFE_CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic short_i,
    output logic expired_o
);
    localparam int LMAX = (GAP_CYCLES > FAILSAFE_CYCLES) ? GAP_CYCLES : FAILSAFE_CYCLES;
    localparam int TW   = $clog2(LMAX + 1);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] lim;

    assign lim       = short_i ? TW'(GAP_CYCLES - 1) : TW'(FAILSAFE_CYCLES - 1);
    assign expired_o = run_i && !clear_i && (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clear_i || !run_i) cnt_q <= '0;
        else if (cnt_q < lim)       cnt_q <= cnt_q + 1'b1;
    end

    AST_EXPIRE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> $past(!clear_i)); // R4

endmodule

// File: rtl/swr_bitsym_rx.sv
module swr_bitsym_rx
    import swr_pkg::*;
#(
    parameter int CLKS_PER_BIT    = 8,
    parameter int GAP_BITS        = 24,
    parameter int ECHO_CHARS      = 8,
    parameter int MAX_BYTES       = 16,
    parameter int FAILSAFE_CYCLES = 4000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           line_i,
    input  logic                           start_i,
    output logic [7:0]                     rsp_data_o,
    output logic                           rsp_valid_o,
    output logic                           rsp_last_o,
    output logic                           done_o,
    output logic [$clog2(MAX_BYTES+1)-1:0] rsp_count_o,
    output logic                           frame_err_o
);
    localparam int GAP_CYCLES = GAP_BITS * CLKS_PER_BIT;
    localparam int CNT_W      = $clog2(MAX_BYTES + 1);
    localparam int EW         = $clog2(ECHO_CHARS + 1);

    seq_state_t state_q, state_d;

    logic       rx_busy, chr_valid, chr_ferr;
    logic [6:0] chr_data;
    logic       sym_bit, sym_valid;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       expired, tmr_run, tmr_clear, tmr_short;
    logic [EW-1:0] echo_q;
    logic       pend_vld_q;
    logic [7:0] pend_q;
    logic       in_rsp;

    swr_char_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chr (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_i),
        .busy_o      (rx_busy),
        .chr_valid_o (chr_valid),
        .chr_data_o  (chr_data),
        .chr_ferr_o  (chr_ferr)
    );

    assign sym_bit   = ((chr_data ^ 7'h7F) < 7'd2);
    assign in_rsp    = (state_q == ST_WAIT) || (state_q == ST_COLLECT);
    assign sym_valid = chr_valid && in_rsp;

    swr_packer u_pack (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (state_q == ST_IDLE),
        .sym_valid_i  (sym_valid),
        .sym_bit_i    (sym_bit),
        .byte_valid_o (byte_valid),
        .byte_o       (byte_data)
    );

    assign tmr_run   = (state_q == ST_ECHO) || in_rsp;
    assign tmr_clear = rx_busy || chr_valid;
    assign tmr_short = (state_q == ST_COLLECT);

    swr_gap_timer #(
        .GAP_CYCLES      (GAP_CYCLES),
        .FAILSAFE_CYCLES (FAILSAFE_CYCLES)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmr_clear),
        .run_i     (tmr_run),
        .short_i   (tmr_short),
        .expired_o (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_ECHO;
            ST_ECHO: begin
                if (expired) state_d = ST_DONE;
                else if (chr_valid && echo_q == EW'(ECHO_CHARS - 1)) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (expired)        state_d = ST_DONE;
                else if (chr_valid) state_d = ST_COLLECT;
            end
            ST_COLLECT: if (expired) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs and per-response storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data_o  <= '0;
            rsp_valid_o <= 1'b0;
            rsp_last_o  <= 1'b0;
            done_o      <= 1'b0;
            rsp_count_o <= '0;
            frame_err_o <= 1'b0;
            echo_q      <= '0;
            pend_vld_q  <= 1'b0;
            pend_q      <= '0;
        end else begin
            rsp_valid_o <= 1'b0;
            rsp_last_o  <= 1'b0;
            done_o      <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    echo_q <= '0;
                    if (start_i) begin
                        rsp_count_o <= '0;
                        frame_err_o <= 1'b0;
                        pend_vld_q  <= 1'b0;
                    end
                end
                ST_ECHO: begin
                    if (chr_valid) echo_q <= echo_q + 1'b1;
                end
                ST_WAIT, ST_COLLECT: begin
                    if (chr_valid && chr_ferr) frame_err_o <= 1'b1;
                    if (byte_valid && rsp_count_o < CNT_W'(MAX_BYTES)) begin
                        if (pend_vld_q) begin
                            rsp_data_o  <= pend_q;
                            rsp_valid_o <= 1'b1;
                        end
                        pend_q      <= byte_data;
                        pend_vld_q  <= 1'b1;
                        rsp_count_o <= rsp_count_o + 1'b1;
                    end
                end
                ST_DONE: begin
                    done_o <= 1'b1;
                    if (pend_vld_q) begin
                        rsp_data_o  <= pend_q;
                        rsp_valid_o <= 1'b1;
                        rsp_last_o  <= 1'b1;
                        pend_vld_q  <= 1'b0;
                    end
                end
                default: begin
                    pend_vld_q <= 1'b0;
                end
            endcase
        end
    end

    AST_LAST_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last_o |-> (rsp_valid_o && done_o)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_count_o <= CNT_W'(MAX_BYTES)); // R6

    AST_ECHO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ECHO) |-> !rsp_valid_o); // R3

    AST_IDLE_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q == ST_IDLE)) |-> !rsp_valid_o); // R10

endmodule

// File: tb/swr_bitsym_rx_tb.sv
module swr_bitsym_rx_tb;
    localparam int CPB  = 8;
    localparam int MAXB = 3;
    localparam int FS   = 600;
    localparam int NV   = 8;

    // {bytes[3:0], extra chars[3:0], variant[3:0], data[31:0]}
    localparam logic [43:0] VEC [NV] = '{
        {4'd1, 4'd0, 4'd0, 32'h000000A5},
        {4'd2, 4'd3, 4'd1, 32'h00003C81},
        {4'd3, 4'd7, 4'd2, 32'h007E0FF0},
        {4'd4, 4'd0, 4'd3, 32'h12345678},
        {4'd0, 4'd5, 4'd0, 32'h00000000},
        {4'd3, 4'd1, 4'd1, 32'h00FF0180},
        {4'd1, 4'd0, 4'd2, 32'h00000001},
        {4'd2, 4'd0, 4'd3, 32'h0000807F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line = 1'b1;
    logic       start = 1'b0;
    logic [7:0] rsp_data;
    logic       rsp_valid, rsp_last, done;
    logic [1:0] rsp_count;
    logic       frame_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] got_b [16];
    logic       got_l [16];
    int  ngot = 0;
    int  ndone = 0;
    bit  done_seen = 0;
    bit  lwd_bad = 0;
    int  done_cnt = 0;
    bit  done_ferr = 0;
    int  done_cyc = 0;

    always #4 clk = ~clk;

    swr_bitsym_rx #(
        .CLKS_PER_BIT(CPB), .GAP_BITS(24), .ECHO_CHARS(8),
        .MAX_BYTES(MAXB), .FAILSAFE_CYCLES(FS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .line_i(line), .start_i(start),
        .rsp_data_o(rsp_data), .rsp_valid_o(rsp_valid), .rsp_last_o(rsp_last),
        .done_o(done), .rsp_count_o(rsp_count), .frame_err_o(frame_err)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && ngot < 16) begin
                got_b[ngot] = rsp_data;
                got_l[ngot] = rsp_last;
                ngot++;
            end
            if (rsp_last && !done) lwd_bad = 1;
            if (done) begin
                done_seen = 1;
                ndone++;
                done_cnt  = int'(rsp_count);
                done_ferr = frame_err;
                done_cyc  = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input logic b, input int v);
        case (v)
            0: return b ? 8'h7F : 8'h7D;
            1: return b ? 8'h7E : 8'h00;
            2: return b ? 8'hFF : 8'hFD;
            default: return b ? 8'hFE : 8'h7C;
        endcase
    endfunction

    task automatic send_char(input logic [7:0] c, input bit bad_stop);
        line = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
            line = c[b];
            repeat (CPB) @(negedge clk);
        end
        line = bad_stop ? 1'b0 : 1'b1;
        repeat (CPB) @(negedge clk);
        line = 1'b1;
        if (bad_stop) repeat (CPB) @(negedge clk);
    endtask

    task automatic clear_mon();
        ngot = 0; ndone = 0; done_seen = 0; lwd_bad = 0; done_cnt = -1; done_ferr = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        int w = 0;
        while (!done_seen && w < 3000) begin
            @(negedge clk);
            w++;
        end
        if (!done_seen) chk(0, "watchdog: no done", 0, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_resp(input int n, input int extra, input int v, input logic [31:0] data,
                            input int ferr_at, input int gap_at, input int gap_len);
        clear_mon();
        pulse_start();
        for (int i = 0; i < 8; i++) send_char(enc(8'h88 >> i, 0), 0);  // echo of request flag
        for (int i = 0; i < n * 8 + extra; i++) begin
            logic bitv;
            bitv = (i < n * 8) ? data[i] : 1'b1;
            send_char(enc(bitv, v), i == ferr_at);
            if (i == gap_at) repeat (gap_len) @(negedge clk);
        end
        wait_done();
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11 reset state
        chk(rsp_valid == 0, "R11 valid", rsp_valid, 0);
        chk(rsp_last == 0, "R11 last", rsp_last, 0);
        chk(done == 0, "R11 done", done, 0);
        chk(rsp_count == 0, "R11 count", rsp_count, 0);
        chk(frame_err == 0, "R11 frame_err", frame_err, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(rsp_valid == 0 && done == 0, "R11 after release", {rsp_valid, done}, 0);

        // table: R1 decode variants, R2 order, R3 echo dropped, R5 leftovers, R6 cap, R7 last
        for (int t = 0; t < NV; t++) begin
            int n, ex, v, k;
            logic [31:0] d;
            n  = int'(VEC[t][43:40]);
            ex = int'(VEC[t][39:36]);
            v  = int'(VEC[t][35:32]);
            d  = VEC[t][31:0];
            k  = (n < MAXB) ? n : MAXB;
            run_resp(n, ex, v, d, -1, -1, 0);
            chk(done_cnt == k, "R6 count", done_cnt, k);
            chk(ngot == k, "R5/R3 bytes delivered", ngot, k);
            for (int j = 0; j < k; j++) begin
                chk(got_b[j] == d[8*j +: 8], "R1/R2/R3 byte value", got_b[j], d[8*j +: 8]);
                chk(got_l[j] == (j == k - 1), "R7 last position", got_l[j], j == k - 1);
            end
            chk(!lwd_bad, "R7 last without done", lwd_bad, 0);
            chk(ndone == 1, "R7 one done", ndone, 1);
            chk(!done_ferr, "R9 no frame error", done_ferr, 0);
        end

        // R8 failsafe with a silent line
        begin
            int t0;
            clear_mon();
            t0 = cyc;
            pulse_start();
            wait_done();
            chk(done_cnt == 0 && ngot == 0, "R8 zero bytes", ngot, 0);
            chk(done_cyc - t0 >= FS && done_cyc - t0 <= FS + 15, "R8 failsafe delay",
                done_cyc - t0, FS);
        end

        // R4 short gap inside a byte does not end the response
        run_resp(1, 0, 0, 32'hC3, -1, 3, 20 * CPB);
        chk(done_cnt == 1 && ngot == 1, "R4 short gap count", ngot, 1);
        chk(got_b[0] == 8'hC3, "R4 short gap byte", got_b[0], 8'hC3);

        // R4 long gap ends it; R10 characters after done are ignored
        run_resp(2, 0, 0, 32'h5AA5, -1, 7, 30 * CPB);
        chk(done_cnt == 1 && ngot == 1, "R4 long gap count", ngot, 1);
        chk(got_b[0] == 8'hA5 && got_l[0] == 1, "R4 long gap byte", got_b[0], 8'hA5);
        repeat (300) @(negedge clk);
        chk(ngot == 1 && ndone == 1, "R10 late chars ignored", ngot, 1);

        // R9 bad stop bit: flag set, bit still counted
        run_resp(1, 0, 0, 32'hFF, 2, -1, 0);
        chk(done_ferr == 1, "R9 frame error set", done_ferr, 1);
        chk(ngot == 1 && got_b[0] == 8'hFF, "R9 char still counted", got_b[0], 8'hFF);
        run_resp(1, 0, 1, 32'h0F, -1, -1, 0);
        chk(done_ferr == 0, "R9 flag cleared by start", done_ferr, 0);
        chk(got_b[0] == 8'h0F, "R1 variant after error", got_b[0], 8'h0F);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule